// File: doc/BRIEF.md
# Serial-Bus VCOM Trim Code Controller

This block is a two-wire serial-bus slave that owns one 7-bit trim code. The code sets an external current DAC, which moves a panel's common-electrode voltage. A host changes the code over the bus. A second kind of write saves the code into nonvolatile storage. The saved value is loaded back into the code register each time the chip comes out of power-on reset, with no bus traffic needed.

The clock and data lines and the write-enable pin are resampled in the system clock domain and filtered, so short spikes have no effect. The slave drives the data line only through an open-drain pull-down enable. Nonvolatile storage sits outside the block and is reached through a request/acknowledge pair. After each programming request a cycle timer runs, and while it runs the slave refuses write addressing.

Bus state machine (`bus_state_t`) states:
- `BS_IDLE`: the bus is free.
- `BS_ADDR`: the address byte is being received.
- `BS_ADDR_ACK`: the slave is acknowledging its address.
- `BS_WR_DATA`: the data byte of a write is being received.
- `BS_WR_ACK`: the slave is acknowledging the data byte.
- `BS_RD_DATA`: the code byte is being sent to the master.
- `BS_RD_ACK`: the master's acknowledge slot after the read byte.
- `BS_WAIT_STOP`: the slave ignores the bus until the next start or stop.

Bus state transitions:
- A stop condition in any state moves to `BS_IDLE`.
- A start condition in any state moves to `BS_ADDR`.
- `BS_ADDR` moves to `BS_ADDR_ACK` when the address matches and the transfer is a read, or is a write while not busy. Otherwise it moves to `BS_WAIT_STOP`.
- `BS_ADDR_ACK` moves to `BS_RD_DATA` or `BS_WR_DATA`, according to the R/W bit.
- `BS_WR_DATA` moves to `BS_WR_ACK` after eight bits, and commits the write at that point.
- `BS_RD_DATA` moves to `BS_RD_ACK` after eight bits.
- `BS_WR_ACK` and `BS_RD_ACK` move to `BS_WAIT_STOP`.

Storage state machine (`nv_state_t`) states and transitions:
- `NS_BOOT` is the state held in reset. It moves to `NS_RECALL`.
- `NS_RECALL` requests a read from storage and moves to `NS_READY` on the acknowledge.
- `NS_READY` moves to `NS_PROG` when a programming write is committed.
- `NS_PROG` holds its write request and moves to `NS_HOLD` on the acknowledge.
- `NS_HOLD` counts `PROG_CYCLES` cycles and then returns to `NS_READY`.

The slave is busy in every storage state except `NS_READY`.

Top module: `vcom_trim_ctrl`

## Requirements
- R1: The slave answers only the 7-bit address 1001111, sent MSB first and followed by the R/W bit (1 = read). It acknowledges by pulling the data line low for the ninth clock. Any other address gets no acknowledge.
- R2: A start is data falling while the clock is high, and a stop is data rising while the clock is high. A stop in the middle of a byte abandons the transfer, and the code is left unchanged.
- R3: A write data byte carries the code in bits 7..1, MSB first, and a target bit in bit 0. With target 1 the code register takes the value. Codes 0 and 127 are accepted like any other.
- R4: With target 0, the byte {code,0} is sent to storage through a write request, and the code register keeps its value.
- R5: A read sends the byte {code register, 1}, MSB first.
- R6: From a programming request until `PROG_CYCLES` cycles after storage acknowledges it, the slave does not acknowledge a write address. A read address is still acknowledged. Once that period ends, writes are accepted again.
- R7: While the write-enable input is low, address and data are acknowledged but the data is discarded: neither the code register nor storage changes.
- R8: After the read byte, the slave leaves the data line released for the master's acknowledge slot.
- R9: A pulse on the clock or data line shorter than `FILT_CYCLES` system clocks is ignored.
- R10: When power-on reset is released, the block requests a storage read and loads bits 7..1 of the returned byte into the code register. The storage default of 80h gives code 64.
- R11: While power-on reset is asserted, the code is 0, the data line is released and no storage request is made.
- R12: A storage request is held, with its direction and data, until storage acknowledges it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| por | input | 1 | power-on reset, active high, asynchronous |
| scl_in | input | 1 | bus clock line as seen at the pad |
| sda_in | input | 1 | bus data line as seen at the pad |
| wp_en | input | 1 | write enable; high allows writes, low (default pull) blocks them |
| sda_pull | output | 1 | open-drain pull-down enable for the data line |
| dac_code | output | 7 | current trim code to the analog DAC |
| nv_req | output | 1 | storage request, held until acknowledged |
| nv_we | output | 1 | request direction: 1 program, 0 read |
| nv_wdata | output | 8 | byte to program |
| nv_ack | input | 1 | one-cycle storage acknowledge |
| nv_rdata | input | 8 | stored byte, valid with nv_ack on a read |

## Verification
The hardest situation to reach is the lockout window. It only exists between a storage programming request and the end of the hold timer, and a host must address the slave inside it. The bench commits a programming write and then, within a few hundred cycles, issues both a write and a read to the slave. It expects the first to be refused and the second to be answered. It then waits out the timer and shows that writes are accepted again. Spikes are placed inside live data bits, on the clock line while it is low and on the data line while the clock is high, so that a missing filter would show up as a spurious start, stop or extra bit.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
    localparam int CODE_W = 7;
    localparam int BYTE_W = CODE_W + 1;
    localparam logic [CODE_W-1:0] DEV_ADDR = 7'b1001111;

    typedef enum logic [2:0] {
        BS_IDLE, BS_ADDR, BS_ADDR_ACK, BS_WR_DATA,
        BS_WR_ACK, BS_RD_DATA, BS_RD_ACK, BS_WAIT_STOP
    } bus_state_t;

    typedef enum logic [2:0] {
        NS_BOOT, NS_RECALL, NS_READY, NS_PROG, NS_HOLD
    } nv_state_t;
endpackage

// File: rtl/vtc_line_filter.sv
module vtc_line_filter #(
    parameter int FILT_CYCLES = 4,
    parameter bit RST_VAL     = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_CYCLES + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // two-flop resample, then accept a new level only after it persists
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sync_q <= {2{RST_VAL}};
            run_q  <= '0;
            clean  <= RST_VAL;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_CYCLES - 1)) begin
                clean <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    generate
        if (FILT_CYCLES >= 2) begin : g_chk
            assert_filter_width_R9: assert property (@(posedge clk) disable iff (rst)
                !$stable(clean) |=> $stable(clean))
                else $error("filtered line toggled on consecutive cycles");
        end
    endgenerate
endmodule

// File: rtl/vtc_bus_fsm.sv
module vtc_bus_fsm
    import vtc_pkg::*;
#(
    parameter logic [CODE_W-1:0] ADDR = DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              sda,
    input  logic              busy,
    input  logic              wr_allow,
    input  logic [CODE_W-1:0] dac_code,
    output logic              sda_pull,
    output logic              dac_wr,
    output logic              nv_wr,
    output logic [CODE_W-1:0] wr_code
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    bus_state_t        state, nxt;
    logic              scl_q, sda_q;
    logic [BYTE_W-1:0] shreg, shreg_n, tx, tx_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              rw, rw_n, dac_wr_n, nv_wr_n;
    logic              scl_rise, scl_fall, start_ev, stop_ev;

    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
    assign start_ev = scl & scl_q & sda_q & ~sda;
    assign stop_ev  = scl & scl_q & ~sda_q & sda;

    always_comb begin
        nxt      = state;
        shreg_n  = shreg;
        tx_n     = tx;
        cnt_n    = cnt;
        rw_n     = rw;
        dac_wr_n = 1'b0;
        nv_wr_n  = 1'b0;
        if (stop_ev) begin
            nxt = BS_IDLE;
        end else if (start_ev) begin
            nxt   = BS_ADDR;
            cnt_n = '0;
        end else begin
            unique case (state)
                BS_IDLE, BS_WAIT_STOP: ;
                BS_ADDR: begin
                    if (scl_rise) begin
                        shreg_n = {shreg[BYTE_W-2:0], sda};
                        cnt_n   = cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                        if (shreg[BYTE_W-1:1] == ADDR && (shreg[0] || !busy)) begin
                            nxt  = BS_ADDR_ACK;
                            rw_n = shreg[0];
                        end else begin
                            nxt = BS_WAIT_STOP;
                        end
                    end
                end
                BS_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_n = '0;
                        if (rw) begin
                            nxt  = BS_RD_DATA;
                            tx_n = {dac_code, 1'b1};
                        end else begin
                            nxt = BS_WR_DATA;
                        end
                    end
                end
                BS_WR_DATA: begin
                    if (scl_rise) begin
                        shreg_n = {shreg[BYTE_W-2:0], sda};
                        cnt_n   = cnt + 1'b1;
                    end else if (scl_fall && cnt == CNT_W'(BYTE_W)) begin
                        nxt = BS_WR_ACK;
                        if (wr_allow) begin
                            dac_wr_n = shreg[0];
                            nv_wr_n  = ~shreg[0];
                        end
                    end
                end
                BS_WR_ACK: if (scl_fall) nxt = BS_WAIT_STOP;
                BS_RD_DATA: begin
                    if (scl_fall) begin
                        if (cnt == CNT_W'(BYTE_W - 1)) begin
                            nxt = BS_RD_ACK;
                        end else begin
                            tx_n  = {tx[BYTE_W-2:0], 1'b1};
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                BS_RD_ACK: if (scl_fall) nxt = BS_WAIT_STOP;
            endcase
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state  <= BS_IDLE;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
            shreg  <= '0;
            tx     <= '1;
            cnt    <= '0;
            rw     <= 1'b0;
            dac_wr <= 1'b0;
            nv_wr  <= 1'b0;
        end else begin
            state  <= nxt;
            scl_q  <= scl;
            sda_q  <= sda;
            shreg  <= shreg_n;
            tx     <= tx_n;
            cnt    <= cnt_n;
            rw     <= rw_n;
            dac_wr <= dac_wr_n;
            nv_wr  <= nv_wr_n;
        end
    end

    always_comb begin
        sda_pull = 1'b0;
        unique case (state)
            BS_ADDR_ACK, BS_WR_ACK: sda_pull = 1'b1;
            BS_RD_DATA:             sda_pull = ~tx[BYTE_W-1];
            default:                sda_pull = 1'b0;
        endcase
    end

    assign wr_code = shreg[BYTE_W-1:1];

    assert_no_write_when_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (state == BS_ADDR_ACK && !rw) |-> !busy)
        else $error("write address accepted while busy");

    assert_release_after_read_R8: assert property (@(posedge clk) disable iff (rst)
        (state == BS_RD_ACK) |-> !sda_pull)
        else $error("data line held in master acknowledge slot");
endmodule

// File: rtl/vtc_nv_ctrl.sv
module vtc_nv_ctrl
    import vtc_pkg::*;
#(
    parameter int PROG_CYCLES = 3000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dac_wr,
    input  logic              nv_wr,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              nv_ack,
    input  logic [BYTE_W-1:0] nv_rdata,
    output logic              nv_req,
    output logic              nv_we,
    output logic [BYTE_W-1:0] nv_wdata,
    output logic [CODE_W-1:0] dac_code,
    output logic              busy
);
    localparam int TMR_W = $clog2(PROG_CYCLES + 1);

    nv_state_t         st;
    logic [TMR_W-1:0]  tmr;
    logic [CODE_W-1:0] code_q;
    logic [BYTE_W-1:0] wdat;
    logic              rd_lsb_unused;

    assign rd_lsb_unused = nv_rdata[0];

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st     <= NS_BOOT;
            tmr    <= '0;
            code_q <= '0;
            wdat   <= '0;
        end else begin
            unique case (st)
                NS_BOOT:   st <= NS_RECALL;
                NS_RECALL: begin
                    if (nv_ack) begin
                        code_q <= nv_rdata[BYTE_W-1:1];
                        st     <= NS_READY;
                    end
                end
                NS_READY: begin
                    if (nv_wr) begin
                        wdat <= {wr_code, 1'b0};
                        st   <= NS_PROG;
                    end
                end
                NS_PROG: begin
                    if (nv_ack) begin
                        tmr <= '0;
                        st  <= NS_HOLD;
                    end
                end
                NS_HOLD: begin
                    if (tmr == TMR_W'(PROG_CYCLES - 1)) st <= NS_READY;
                    else                               tmr <= tmr + 1'b1;
                end
                default: st <= NS_BOOT;
            endcase
            if (dac_wr) code_q <= wr_code;
        end
    end

    always_comb begin
        nv_req   = (st == NS_RECALL) || (st == NS_PROG);
        nv_we    = (st == NS_PROG);
        nv_wdata = wdat;
        busy     = (st != NS_READY);
        dac_code = code_q;
    end

    assert_req_held_R12: assert property (@(posedge clk) disable iff (rst)
        (nv_req && !nv_ack) |=> (nv_req && $stable(nv_we) && $stable(nv_wdata)))
        else $error("storage request dropped before acknowledge");

    assert_prog_then_busy_R6: assert property (@(posedge clk) disable iff (rst)
        nv_wr |=> busy)
        else $error("programming commit did not raise busy");

    assert_code_source_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(code_q) |-> ($past(dac_wr) || $past(nv_ack && !nv_we)))
        else $error("code changed without a write or recall");
endmodule

// File: rtl/vcom_trim_ctrl.sv
module vcom_trim_ctrl
    import vtc_pkg::*;
#(
    parameter int FILT_CYCLES = 4,
    parameter int PROG_CYCLES = 3000
) (
    input  logic              clk,
    input  logic              por,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic              wp_en,
    output logic [CODE_W-1:0] dac_code,
    output logic              nv_req,
    output logic              nv_we,
    output logic [BYTE_W-1:0] nv_wdata,
    input  logic              nv_ack,
    input  logic [BYTE_W-1:0] nv_rdata
);
    localparam int LINES   = 3;
    localparam int SCL_IDX = 0;
    localparam int SDA_IDX = 1;
    localparam int WP_IDX  = 2;

    logic [LINES-1:0]  raw, clean;
    logic              busy, dac_wr, nv_wr;
    logic [CODE_W-1:0] wr_code;

    assign raw = {wp_en, sda_in, scl_in};

    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            vtc_line_filter #(
                .FILT_CYCLES(FILT_CYCLES),
                .RST_VAL    ((g == WP_IDX) ? 1'b0 : 1'b1)
            ) u_filt (
                .clk  (clk),
                .rst  (por),
                .raw  (raw[g]),
                .clean(clean[g])
            );
        end
    endgenerate

    vtc_bus_fsm u_bus (
        .clk     (clk),
        .rst     (por),
        .scl     (clean[SCL_IDX]),
        .sda     (clean[SDA_IDX]),
        .busy    (busy),
        .wr_allow(clean[WP_IDX]),
        .dac_code(dac_code),
        .sda_pull(sda_pull),
        .dac_wr  (dac_wr),
        .nv_wr   (nv_wr),
        .wr_code (wr_code)
    );

    vtc_nv_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_nv (
        .clk     (clk),
        .rst     (por),
        .dac_wr  (dac_wr),
        .nv_wr   (nv_wr),
        .wr_code (wr_code),
        .nv_ack  (nv_ack),
        .nv_rdata(nv_rdata),
        .nv_req  (nv_req),
        .nv_we   (nv_we),
        .nv_wdata(nv_wdata),
        .dac_code(dac_code),
        .busy    (busy)
    );
endmodule

// File: tb/sim_vcom_trim_ctrl.sv
module sim_vcom_trim_ctrl;
    localparam int Q = 8;
    localparam int H = 16;
    localparam int PROG = 3000;
    localparam logic [6:0] ME = 7'b1001111;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       scl_m = 1'b1, sda_m = 1'b1, wp = 1'b0;
    logic       sda_pull, nv_req, nv_we;
    logic       nv_ack = 1'b0;
    logic [6:0] dac_code;
    logic [7:0] nv_wdata;
    logic [7:0] nv_mem = 8'h80;
    wire        sda_bus = sda_m & ~sda_pull;

    int         total = 0, bad = 0, nv_writes = 0, lat = 0;
    bit         done = 1'b0, chk_en = 1'b0;
    logic [6:0] exp_dac = '0;

    always #2.5 clk = ~clk;

    vcom_trim_ctrl #(.FILT_CYCLES(4), .PROG_CYCLES(PROG)) u0 (
        .clk(clk), .por(por), .scl_in(scl_m), .sda_in(sda_bus), .sda_pull(sda_pull),
        .wp_en(wp), .dac_code(dac_code), .nv_req(nv_req), .nv_we(nv_we),
        .nv_wdata(nv_wdata), .nv_ack(nv_ack), .nv_rdata(nv_mem)
    );

    // storage model: acknowledges a request after a few cycles
    always @(posedge clk) begin
        if (por) begin
            lat = 0;
            nv_ack <= 1'b0;
        end else if (nv_req && !nv_ack) begin
            if (lat == 3) begin
                nv_ack <= 1'b1;
                lat = 0;
                if (nv_we) begin
                    nv_mem <= nv_wdata;
                    nv_writes <= nv_writes + 1;
                end
            end else begin
                lat = lat + 1;
            end
        end else begin
            nv_ack <= 1'b0;
        end
    end

    // per-clock comparison of the code against the model
    always @(negedge clk) begin
        if (chk_en && !done) begin
            total++;
            if (dac_code !== exp_dac) begin
                bad++;
                $display("FAIL R3 model code actual=%0d expected=%0d", dac_code, exp_dac);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
        end
    endtask

    task automatic bit_slot(input logic d, input bit gl, output logic s);
        tick(Q);
        sda_m = d;
        if (gl) begin
            tick(4); scl_m = 1'b1; tick(2); scl_m = 1'b0; tick(H - 6);
        end else tick(H);
        scl_m = 1'b1;
        if (gl) begin
            tick(4); sda_m = ~d; tick(2); sda_m = d; tick(H / 2 - 6);
        end else tick(H / 2);
        s = sda_bus;
        tick(H / 2);
        scl_m = 1'b0;
    endtask

    task automatic start_c();
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0;
    endtask

    task automatic stop_c();
        tick(Q); sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit gl, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_slot(b[i], gl, s);
        bit_slot(1'b1, 1'b0, s);
        ack = ~s;
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] d, input bit gl,
                          output logic aa, output logic ad);
        start_c();
        send_byte({a, 1'b0}, 1'b0, aa);
        ad = 1'b0;
        if (aa) send_byte(d, gl, ad);
        stop_c();
    endtask

    task automatic rd_txn(input logic [6:0] a, output logic aa, output logic [7:0] d,
                          output logic rel);
        logic s;
        start_c();
        send_byte({a, 1'b1}, 1'b0, aa);
        d = '0;
        rel = 1'b0;
        if (aa) begin
            for (int i = 7; i >= 0; i--) begin
                bit_slot(1'b1, 1'b0, s);
                d[i] = s;
            end
            bit_slot(1'b1, 1'b0, rel);
        end
        stop_c();
    endtask

    initial begin
        logic aa, ad, rel, s;
        logic [7:0] rd;
        tick(10);
        check("R11 code in reset", dac_code, 0);
        check("R11 pull in reset", sda_pull, 0);
        check("R11 no request in reset", nv_req, 0);
        por = 1'b0;
        tick(2);
        check("R10 recall request", nv_req, 1);
        check("R10 recall is a read", nv_we, 0);
        tick(20);
        check("R10 default recall code", dac_code, 64);
        exp_dac = 7'd64; chk_en = 1'b1;
        wp = 1'b1; tick(10);

        chk_en = 1'b0;
        wr_txn(ME, {7'd100, 1'b1}, 1'b0, aa, ad);
        exp_dac = 7'd100; chk_en = 1'b1;
        check("R1 address ack", aa, 1);
        check("R3 data ack", ad, 1);
        check("R3 code loaded", dac_code, 100);
        check("R3 storage untouched", nv_mem, 8'h80);

        rd_txn(ME, aa, rd, rel);
        check("R1 read address ack", aa, 1);
        check("R5 read byte", rd, 8'hC9);
        check("R8 line released after read", rel, 1);

        wr_txn(7'b1001110, {7'd3, 1'b1}, 1'b0, aa, ad);
        check("R1 foreign address refused", aa, 0);
        check("R1 code kept", dac_code, 100);

        wp = 1'b0; tick(10);
        wr_txn(ME, {7'd5, 1'b1}, 1'b0, aa, ad);
        check("R7 address acked when locked", aa, 1);
        check("R7 data acked when locked", ad, 1);
        check("R7 code kept", dac_code, 100);
        wr_txn(ME, {7'd9, 1'b0}, 1'b0, aa, ad);
        check("R7 program data acked", ad, 1);
        tick(50);
        check("R7 no storage write", nv_writes, 0);
        check("R7 storage kept", nv_mem, 8'h80);
        wp = 1'b1; tick(10);

        chk_en = 1'b0;
        wr_txn(ME, {7'd42, 1'b1}, 1'b1, aa, ad);
        exp_dac = 7'd42; chk_en = 1'b1;
        check("R9 write through spikes acked", ad, 1);
        check("R9 code after spikes", dac_code, 42);

        start_c();
        send_byte({ME, 1'b0}, 1'b0, aa);
        bit_slot(1'b1, 1'b0, s);
        bit_slot(1'b0, 1'b0, s);
        bit_slot(1'b1, 1'b0, s);
        stop_c();
        check("R2 aborted write addr ack", aa, 1);
        check("R2 code after abort", dac_code, 42);

        wr_txn(ME, {7'd33, 1'b0}, 1'b0, aa, ad);
        check("R4 program ack", ad, 1);
        check("R4 code unchanged by program", dac_code, 42);
        tick(20);
        check("R4 R12 stored byte", nv_mem, 8'h42);
        check("R4 one storage write", nv_writes, 1);

        wr_txn(ME, {7'd10, 1'b1}, 1'b0, aa, ad);
        check("R6 write refused while busy", aa, 0);
        check("R6 code kept while busy", dac_code, 42);
        rd_txn(ME, aa, rd, rel);
        check("R6 read acked while busy", aa, 1);
        check("R6 R5 read while busy", rd, 8'h55);

        tick(PROG + 200);
        chk_en = 1'b0;
        wr_txn(ME, {7'd127, 1'b1}, 1'b0, aa, ad);
        exp_dac = 7'd127; chk_en = 1'b1;
        check("R6 write accepted after busy", aa, 1);
        check("R3 full scale code", dac_code, 127);
        chk_en = 1'b0;
        wr_txn(ME, {7'd0, 1'b1}, 1'b0, aa, ad);
        exp_dac = 7'd0; chk_en = 1'b1;
        check("R3 zero code", dac_code, 0);
        rd_txn(ME, aa, rd, rel);
        check("R5 read zero code", rd, 8'h01);

        chk_en = 1'b0;
        por = 1'b1; tick(5);
        check("R11 code in second reset", dac_code, 0);
        por = 1'b0; tick(30);
        check("R10 recall of programmed code", dac_code, 33);
        exp_dac = 7'd33; chk_en = 1'b1;
        tick(20);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(150000);
        if (!done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule